// File: doc/BRIEF.md
# Compressed Min-Sum Check Node State

This block holds the running state of a single min-sum check node in compact form. Bit-to-check messages arrive one arc per cycle during a serial sweep over the bit nodes. The block does not store every message. It keeps four values: the smallest magnitude seen, the second-smallest magnitude, the arc index that produced the smallest, and the parity of all hard bits. Only magnitude compares and XOR are used. No channel noise estimate and no nonlinear function are needed.

A second, read-only port rebuilds the check-to-bit message for any arc. The caller supplies the arc index and that arc's own hard bit. The block returns the outgoing magnitude and sign from the registered state.

The update port is a valid/ready stream that never applies back-pressure. `upd_ready` is high at all times after reset, so every cycle with `upd_valid` high folds in one message. A producer may therefore hold `upd_valid` high on consecutive cycles. Messages are sign-magnitude values. Bit 5 is the hard bit (1 = negative) and bits 4:0 are the magnitude. Arc indices are 5 bits wide, which covers up to 32 arcs.

Top module: `cn_minsum_state`

## Requirements
- R1: After reset, or after a clear, the stored minimum and second minimum are both 31, the stored index is 0 and the parity is 0. A read then returns magnitude 31 and a sign equal to `rd_hard`.
- R2: An accepted update whose magnitude is strictly below the stored minimum moves the old minimum into the second minimum. The new magnitude and its arc index become the minimum.
- R3: An accepted update whose magnitude is at least the minimum but strictly below the second minimum replaces only the second minimum.
- R4: On a magnitude equal to the stored minimum, the earlier arc index stays the minimum index. The new value can only enter the second minimum.
- R5: Each accepted update XORs its hard bit (bit 5) into the parity. The read sign equals parity XOR `rd_hard`.
- R6: The read magnitude is the second minimum when `rd_idx` equals the stored minimum index, and the minimum otherwise. The read port is combinational from the registered state.
- R7: An update takes effect at the next rising clock edge. A cycle without `upd_valid` leaves the state unchanged, whatever the data inputs carry.
- R8: `clear` is synchronous and has priority over a simultaneous update, which is discarded.
- R9: `upd_ready` is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous state initialisation for a new sweep |
| upd_valid | input | 1 | Update message valid |
| upd_ready | output | 1 | Update accepted (always high) |
| upd_llr | input | 6 | Incoming message: bit 5 hard bit, bits 4:0 magnitude |
| upd_idx | input | 5 | Arc index of the incoming message |
| rd_idx | input | 5 | Arc index whose outgoing message is requested |
| rd_hard | input | 1 | Hard bit of the requested arc |
| rd_mag | output | 5 | Outgoing magnitude for `rd_idx` |
| rd_sign | output | 1 | Outgoing sign for `rd_idx` |

## Verification
A corrupted minimum or second minimum shows on `rd_mag` one cycle after the faulty update, for reads of any arc or of the argmin arc respectively. A wrong argmin index swaps which of the two magnitudes the argmin arc and the other arcs receive. A parity slip flips `rd_sign` for every arc from the next cycle onward, and stays flipped until the next clear. The vectors read after each update the arcs whose answer would differ under such faults, including ties and idle cycles.

// File: rtl/cn_minsum_pkg.sv
package cn_minsum_pkg;

  localparam int DEF_MAG_W = 5;
  localparam int DEF_IDX_W = 5;

  // Action selected for the state registers in a cycle
  typedef enum logic [2:0] {
    ACT_HOLD     = 3'd0,
    ACT_INIT     = 3'd1,
    ACT_PAR_ONLY = 3'd2,
    ACT_NEW_MIN  = 3'd3,
    ACT_NEW_SEC  = 3'd4
  } cn_act_e;

endpackage

// File: rtl/cn_upd_classify.sv
module cn_upd_classify
  import cn_minsum_pkg::*;
#(
  parameter int MAG_W = DEF_MAG_W
) (
  input  logic             clear,
  input  logic             valid,
  input  logic [MAG_W-1:0] in_mag,
  input  logic [MAG_W-1:0] cur_min,
  input  logic [MAG_W-1:0] cur_sec,
  output cn_act_e          act
);

  logic below_min;
  logic below_sec;

  // Strict compares: ties never displace the earlier argmin
  assign below_min = in_mag < cur_min;
  assign below_sec = in_mag < cur_sec;

  always_comb begin
    if (clear)          act = ACT_INIT;
    else if (!valid)    act = ACT_HOLD;
    else if (below_min) act = ACT_NEW_MIN;
    else if (below_sec) act = ACT_NEW_SEC;
    else                act = ACT_PAR_ONLY;
  end

endmodule

// File: rtl/cn_state_regs.sv
module cn_state_regs
  import cn_minsum_pkg::*;
#(
  parameter int MAG_W = DEF_MAG_W,
  parameter int IDX_W = DEF_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cn_act_e          act,
  input  logic [MAG_W-1:0] in_mag,
  input  logic [IDX_W-1:0] in_idx,
  input  logic             in_hard,
  output logic [MAG_W-1:0] min_q,
  output logic [MAG_W-1:0] sec_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             par_q
);

  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= MAG_MAX;
      sec_q <= MAG_MAX;
      idx_q <= '0;
      par_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_INIT: begin
          min_q <= MAG_MAX;
          sec_q <= MAG_MAX;
          idx_q <= '0;
          par_q <= 1'b0;
        end
        ACT_NEW_MIN: begin
          sec_q <= min_q;
          min_q <= in_mag;
          idx_q <= in_idx;
          par_q <= par_q ^ in_hard;
        end
        ACT_NEW_SEC: begin
          sec_q <= in_mag;
          par_q <= par_q ^ in_hard;
        end
        ACT_PAR_ONLY: begin
          par_q <= par_q ^ in_hard;
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/cn_extr_read.sv
module cn_extr_read
  import cn_minsum_pkg::*;
#(
  parameter int MAG_W = DEF_MAG_W,
  parameter int IDX_W = DEF_IDX_W
) (
  input  logic [MAG_W-1:0] min_q,
  input  logic [MAG_W-1:0] sec_q,
  input  logic [IDX_W-1:0] idx_q,
  input  logic             par_q,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_hard,
  output logic [MAG_W-1:0] rd_mag,
  output logic             rd_sign
);

  logic is_argmin;

  assign is_argmin = (rd_idx == idx_q);
  assign rd_mag    = is_argmin ? sec_q : min_q;
  // Removing the arc's own contribution from the total parity
  assign rd_sign   = par_q ^ rd_hard;

endmodule

// File: rtl/cn_minsum_state.sv
module cn_minsum_state
  import cn_minsum_pkg::*;
#(
  parameter int MAG_W = DEF_MAG_W,
  parameter int IDX_W = DEF_IDX_W,
  localparam int LLR_W = MAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [LLR_W-1:0] upd_llr,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_hard,
  output logic [MAG_W-1:0] rd_mag,
  output logic             rd_sign
);

  logic [MAG_W-1:0] st_min;
  logic [MAG_W-1:0] st_sec;
  logic [IDX_W-1:0] st_idx;
  logic             st_par;
  logic [MAG_W-1:0] in_mag;
  logic             in_hard;
  cn_act_e          act;

  assign in_mag    = upd_llr[MAG_W-1:0];
  assign in_hard   = upd_llr[LLR_W-1];
  assign upd_ready = 1'b1;

  cn_upd_classify #(.MAG_W(MAG_W)) u_cls (
    .clear   (clear),
    .valid   (upd_valid),
    .in_mag  (in_mag),
    .cur_min (st_min),
    .cur_sec (st_sec),
    .act     (act)
  );

  cn_state_regs #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .in_mag  (in_mag),
    .in_idx  (upd_idx),
    .in_hard (in_hard),
    .min_q   (st_min),
    .sec_q   (st_sec),
    .idx_q   (st_idx),
    .par_q   (st_par)
  );

  cn_extr_read #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_rd (
    .min_q   (st_min),
    .sec_q   (st_sec),
    .idx_q   (st_idx),
    .par_q   (st_par),
    .rd_idx  (rd_idx),
    .rd_hard (rd_hard),
    .rd_mag  (rd_mag),
    .rd_sign (rd_sign)
  );

endmodule

// File: rtl/cn_minsum_state_chk.sv
module cn_minsum_state_chk #(
  parameter int MAG_W = 5,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             upd_valid,
  input logic [MAG_W:0]   upd_llr,
  input logic [IDX_W-1:0] upd_idx,
  input logic [MAG_W-1:0] st_min,
  input logic [MAG_W-1:0] st_sec,
  input logic [IDX_W-1:0] st_idx,
  input logic             st_par,
  input logic [MAG_W-1:0] rd_mag
);

  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

  logic             acc;
  logic [MAG_W-1:0] mag;
  assign acc = upd_valid && !clear;
  assign mag = upd_llr[MAG_W-1:0];

  a_r1_clear_init: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (st_min == MAG_MAX) && (st_sec == MAG_MAX) && (st_idx == '0) && !st_par);

  a_r2_new_min: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (mag < st_min)) |=> (st_min == $past(mag)) && (st_sec == $past(st_min))
                                && (st_idx == $past(upd_idx)));

  a_r3_second_only: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (mag >= st_min) && (mag < st_sec)) |=> (st_sec == $past(mag))
                                && $stable(st_min) && $stable(st_idx));

  a_r4_tie_keeps_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (mag == st_min)) |=> $stable(st_idx) && $stable(st_min));

  a_r5_parity_fold: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> st_par == ($past(st_par) ^ $past(upd_llr[MAG_W])));

  a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
    st_min <= st_sec);

  a_r6_read_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mag == st_min) || (rd_mag == st_sec));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !clear) |=> $stable(st_min) && $stable(st_sec)
                               && $stable(st_idx) && $stable(st_par));

endmodule

bind cn_minsum_state cn_minsum_state_chk #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear     (clear),
  .upd_valid (upd_valid),
  .upd_llr   (upd_llr),
  .upd_idx   (upd_idx),
  .st_min    (st_min),
  .st_sec    (st_sec),
  .st_idx    (st_idx),
  .st_par    (st_par),
  .rd_mag    (rd_mag)
);

// File: tb/cn_minsum_state_test.sv
module cn_minsum_state_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  // [24] clear [23] valid [22:17] llr [16:12] idx [11:7] rd_idx [6] rd_hard
  // [5:1] expected magnitude [0] expected sign
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd0,          5'd0,  5'd0,  1'b0, 5'd31, 1'b0}, // R1 clear
    {1'b0, 1'b1, {1'b0, 5'd10}, 5'd0,  5'd0,  1'b0, 5'd31, 1'b0}, // R2 first
    {1'b0, 1'b1, {1'b1, 5'd7},  5'd1,  5'd1,  1'b1, 5'd10, 1'b0}, // R2 shift
    {1'b0, 1'b1, {1'b0, 5'd12}, 5'd2,  5'd2,  1'b0, 5'd7,  1'b1}, // R5 no mag change
    {1'b0, 1'b1, {1'b1, 5'd8},  5'd3,  5'd1,  1'b1, 5'd8,  1'b1}, // R3 second only
    {1'b0, 1'b1, {1'b0, 5'd7},  5'd4,  5'd1,  1'b1, 5'd7,  1'b1}, // R4 tie
    {1'b0, 1'b1, {1'b0, 5'd2},  5'd5,  5'd5,  1'b0, 5'd7,  1'b0}, // R2 argmin read
    {1'b0, 1'b0, {1'b1, 5'd0},  5'd6,  5'd6,  1'b0, 5'd2,  1'b0}, // R7 idle
    {1'b0, 1'b1, {1'b1, 5'd0},  5'd6,  5'd7,  1'b1, 5'd0,  1'b0}, // R6 non-argmin
    {1'b0, 1'b1, {1'b0, 5'd31}, 5'd31, 5'd6,  1'b0, 5'd2,  1'b1}, // R6 argmin
    {1'b1, 1'b1, {1'b1, 5'd3},  5'd2,  5'd2,  1'b0, 5'd31, 1'b0}, // R8 clear wins
    {1'b0, 1'b1, {1'b0, 5'd31}, 5'd9,  5'd0,  1'b0, 5'd31, 1'b0}, // R4 tie at max
    {1'b0, 1'b1, {1'b0, 5'd0},  5'd31, 5'd31, 1'b1, 5'd31, 1'b1}, // R2 top index
    {1'b0, 1'b0, 6'd0,          5'd0,  5'd30, 1'b0, 5'd0,  1'b0}  // R6 other arc
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       upd_valid = 1'b0;
  logic       upd_ready;
  logic [5:0] upd_llr = '0;
  logic [4:0] upd_idx = '0;
  logic [4:0] rd_idx = '0;
  logic       rd_hard = 1'b0;
  logic [4:0] rd_mag;
  logic       rd_sign;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cn_minsum_state uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .upd_valid (upd_valid),
    .upd_ready (upd_ready),
    .upd_llr   (upd_llr),
    .upd_idx   (upd_idx),
    .rd_idx    (rd_idx),
    .rd_hard   (rd_hard),
    .rd_mag    (rd_mag),
    .rd_sign   (rd_sign)
  );

  task automatic check(input string req, input logic [4:0] em, input logic es);
    n_chk++;
    if (rd_mag !== em || rd_sign !== es) begin
      n_bad++;
      $display("FAIL %s: mag=%0d sign=%0b expected mag=%0d sign=%0b",
               req, rd_mag, rd_sign, em, es);
    end
  endtask

  task automatic check_ready(input string req);
    n_chk++;
    if (upd_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: upd_ready=%0b expected 1", req, upd_ready);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state, read arc 3 with hard bit 1
    rd_idx  = 5'd3;
    rd_hard = 1'b1;
    #1 check("R1 reset", 5'd31, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_ready("R9 after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clear     = VEC[i][24];
      upd_valid = VEC[i][23];
      upd_llr   = VEC[i][22:17];
      upd_idx   = VEC[i][16:12];
      rd_idx    = VEC[i][11:7];
      rd_hard   = VEC[i][6];
      @(posedge clk);
      #1 check($sformatf("R1-8 vector %0d", i), VEC[i][5:1], VEC[i][0]);
      check_ready("R9 stream");
    end

    // State now: min 0 @31, sec 31, parity 0. Idle with garbage data (R7)
    @(negedge clk);
    clear = 1'b0;
    upd_valid = 1'b0;
    upd_llr = {1'b1, 5'd1};
    upd_idx = 5'd4;
    rd_idx = 5'd4;
    rd_hard = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R7 idle garbage", 5'd0, 1'b0);

    // Back-to-back updates (R2, R3, R5)
    @(negedge clk);
    upd_valid = 1'b1;
    upd_llr = {1'b1, 5'd5};
    upd_idx = 5'd8;
    @(negedge clk);
    upd_llr = {1'b1, 5'd3};
    upd_idx = 5'd9;
    @(negedge clk);
    upd_valid = 1'b0;
    rd_idx = 5'd31;
    rd_hard = 1'b0;
    #1 check("R3 back-to-back second", 5'd3, 1'b0);

    // Mid-run reset restores R1 state
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async reset", 5'd31, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_hard = 1'b1;
    #1 check("R5 sign after reset", 5'd31, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule